// File: doc/BRIEF.md
# UART FIFO Trigger Interrupt Controller

This block turns the occupancy counts of a UART's two 64-entry FIFOs into interrupt requests. The receive-threshold interrupt stays high while enough characters are waiting to be read. The transmit-refill interrupt asks software for more data. A status bit reports when the transmit FIFO has run dry. The datapath supplies the receive count, the transmit count and a flag showing that the transmit shifter is busy. Software supplies the trigger-level fields and the mode bits.

The receive trigger has two encodings. A coarse mode uses a 2-bit selector that picks one of four fixed levels. A fine mode joins a 4-bit upper field to the same 2-bit selector, which gives any level from 1 to 63. The transmit threshold counts free spaces and has the same two encodings. A separate mode bit changes the transmit interrupt from threshold operation to "whole lane empty" operation.

The configuration is registered once. The outputs are combinational functions of the current counts and the registered configuration, so no interrupt edge is latched.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset, with both counts at 0 and the shifter idle, rx_irq_o is 0, and tx_irq_o and tx_fifo_empty_o are both 1.
- R2: With rx_fine_i=0, the receive level is selected by rx_sel_i: 0 gives 8, 1 gives 16, 2 gives 56 and 3 gives 60 characters.
- R3: With rx_fine_i=1, the receive level is the 6-bit value {rx_hi_i, rx_sel_i}, with rx_hi_i in the upper four bits. This covers every level from 1 to 63.
- R4: In fine mode, a joined value of 0 acts as a level of 1. This applies to both the receive and the transmit sides.
- R5: rx_irq_o is 1 exactly while rx_count_i is at or above the receive level. It drops in the same cycle that the count falls below the level.
- R6: With tx_empty_mode_i=1, tx_irq_o is 1 only when tx_count_i is 0 and tx_shift_busy_i is 0.
- R7: With tx_empty_mode_i=0, tx_irq_o is 1 when the free space (64 minus tx_count_i) is at or above the transmit level. It is also 1 whenever the lane is fully empty.
- R8: With tx_fine_i=0, the transmit level in free spaces is selected by tx_sel_i: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 56. With tx_fine_i=1, the level is {tx_hi_i, tx_sel_i}.
- R9: tx_fifo_empty_o is 1 exactly when tx_count_i is 0, whatever the state of the shifter.
- R10: A change to any configuration input affects the outputs from the clock edge after it is applied. A change to a count affects the outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_count_i | input | 7 | Receive FIFO occupancy (0..64) |
| tx_count_i | input | 7 | Transmit FIFO occupancy (0..64) |
| tx_shift_busy_i | input | 1 | Transmit shift register is still sending |
| rx_fine_i | input | 1 | Receive level uses the 1-step encoding |
| rx_sel_i | input | 2 | Receive coarse selector, or the low bits of the fine level |
| rx_hi_i | input | 4 | Receive fine level, upper bits |
| tx_fine_i | input | 1 | Transmit level uses the 1-step encoding |
| tx_sel_i | input | 2 | Transmit coarse selector, or the low bits of the fine level |
| tx_hi_i | input | 4 | Transmit fine level, upper bits |
| tx_empty_mode_i | input | 1 | Transmit interrupt only when the whole lane is empty |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| tx_irq_o | output | 1 | Transmit refill interrupt |
| tx_fifo_empty_o | output | 1 | Transmit FIFO empty status |

## Verification
Each coarse receive selector and several fine levels, including 1, 63 and the zero code, are tried with the count set to the level minus one and then to the level. A wrong table entry or an off-by-one compare shows up as a wrong output at one of those two points. The transmit side is swept across its free-space boundary in both encodings. The lane-empty case is tried with the shifter busy and with it idle, in both transmit modes, which separates threshold operation, empty-lane operation and the status bit. A configuration change is checked before and after the next clock edge to pin down its one-cycle latency.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
  localparam int unsigned LVL_W = 6;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned HI_W  = LVL_W - SEL_W;

  typedef struct packed {
    logic             fine;
    logic [SEL_W-1:0] sel;
    logic [HI_W-1:0]  hi;
  } lvl_cfg_t;

  function automatic logic [LVL_W-1:0] rx_coarse(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return LVL_W'(8);
      2'd1:    return LVL_W'(16);
      2'd2:    return LVL_W'(56);
      default: return LVL_W'(60);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] tx_coarse(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return LVL_W'(8);
      2'd1:    return LVL_W'(16);
      2'd2:    return LVL_W'(32);
      default: return LVL_W'(56);
    endcase
  endfunction
endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
  import uart_trig_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_cfg_t rx_cfg_i,
  input  lvl_cfg_t tx_cfg_i,
  input  logic     tx_empty_mode_i,
  output lvl_cfg_t rx_cfg_o,
  output lvl_cfg_t tx_cfg_o,
  output logic     tx_empty_mode_o
);
  // reset: coarse mode, selector 0, normal transmit mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cfg_o        <= '0;
      tx_cfg_o        <= '0;
      tx_empty_mode_o <= 1'b0;
    end else begin
      rx_cfg_o        <= rx_cfg_i;
      tx_cfg_o        <= tx_cfg_i;
      tx_empty_mode_o <= tx_empty_mode_i;
    end
  end
endmodule

// File: rtl/trig_level_dec.sv
module trig_level_dec
  import uart_trig_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  lvl_cfg_t         cfg_i,
  output logic [LVL_W-1:0] level_o
);
  logic [LVL_W-1:0] coarse;
  logic [LVL_W-1:0] fine_raw;

  generate
    if (IS_TX) begin : g_tx_tab
      assign coarse = tx_coarse(cfg_i.sel);
    end else begin : g_rx_tab
      assign coarse = rx_coarse(cfg_i.sel);
    end
  endgenerate

  assign fine_raw = {cfg_i.hi, cfg_i.sel};

  always_comb begin
    if (!cfg_i.fine)        level_o = coarse;
    else if (fine_raw == '0) level_o = LVL_W'(1); // zero code is clamped to one
    else                    level_o = fine_raw;
  end
endmodule

// File: rtl/tx_irq_gen.sv
module tx_irq_gen
  import uart_trig_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             busy_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             empty_mode_i,
  output logic             irq_o,
  output logic             fifo_empty_o
);
  logic [CNT_W-1:0] free_sp;
  logic             lane_idle;
  logic             room_ok;

  assign free_sp      = CNT_W'(DEPTH) - count_i;
  assign fifo_empty_o = (count_i == '0);
  assign lane_idle    = fifo_empty_o && !busy_i;
  assign room_ok      = free_sp >= CNT_W'(level_i);
  assign irq_o        = empty_mode_i ? lane_idle : (room_ok || lane_idle);
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
  import uart_trig_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             tx_shift_busy_i,
  input  logic             rx_fine_i,
  input  logic [SEL_W-1:0] rx_sel_i,
  input  logic [HI_W-1:0]  rx_hi_i,
  input  logic             tx_fine_i,
  input  logic [SEL_W-1:0] tx_sel_i,
  input  logic [HI_W-1:0]  tx_hi_i,
  input  logic             tx_empty_mode_i,
  output logic             rx_irq_o,
  output logic             tx_irq_o,
  output logic             tx_fifo_empty_o
);
  lvl_cfg_t         rx_cfg_d, tx_cfg_d, rx_cfg_q, tx_cfg_q;
  logic             tx_mode_q;
  logic [LVL_W-1:0] rx_level, tx_level;

  assign rx_cfg_d = '{fine: rx_fine_i, sel: rx_sel_i, hi: rx_hi_i};
  assign tx_cfg_d = '{fine: tx_fine_i, sel: tx_sel_i, hi: tx_hi_i};

  trig_cfg_reg u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rx_cfg_i       (rx_cfg_d),
    .tx_cfg_i       (tx_cfg_d),
    .tx_empty_mode_i(tx_empty_mode_i),
    .rx_cfg_o       (rx_cfg_q),
    .tx_cfg_o       (tx_cfg_q),
    .tx_empty_mode_o(tx_mode_q)
  );

  trig_level_dec #(.IS_TX(1'b0)) u_rx_lvl (.cfg_i(rx_cfg_q), .level_o(rx_level));
  trig_level_dec #(.IS_TX(1'b1)) u_tx_lvl (.cfg_i(tx_cfg_q), .level_o(tx_level));

  assign rx_irq_o = rx_count_i >= CNT_W'(rx_level);

  tx_irq_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .count_i     (tx_count_i),
    .busy_i      (tx_shift_busy_i),
    .level_i     (tx_level),
    .empty_mode_i(tx_mode_q),
    .irq_o       (tx_irq_o),
    .fifo_empty_o(tx_fifo_empty_o)
  );
endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic             tx_shift_busy_i,
  input logic             tx_empty_mode_i,
  input logic             rx_irq_o,
  input logic             tx_irq_o,
  input logic             tx_fifo_empty_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R6: empty mode fires only on a fully idle lane
  a_r6_empty_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(tx_empty_mode_i) && tx_irq_o) |-> (tx_count_i == '0 && !tx_shift_busy_i));

  // R7: an idle lane always requests data
  a_r7_idle_lane_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_i == '0 && !tx_shift_busy_i) |-> tx_irq_o);

  // R5: levels are at least 1, so an empty receive FIFO never interrupts
  a_r5_rx_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == '0) |-> !rx_irq_o);

  // R5: a full receive FIFO is above every level
  a_r5_rx_full_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == CNT_W'(DEPTH)) |-> rx_irq_o);

  // R9: empty status follows the transmit count only
  a_r9_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fifo_empty_o |-> (tx_count_i == '0));

  a_r9_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_i == '0 && tx_shift_busy_i) |-> tx_fifo_empty_o);
endmodule

bind uart_fifo_trig uart_fifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_count_i     (rx_count_i),
  .tx_count_i     (tx_count_i),
  .tx_shift_busy_i(tx_shift_busy_i),
  .tx_empty_mode_i(tx_empty_mode_i),
  .rx_irq_o       (rx_irq_o),
  .tx_irq_o       (tx_irq_o),
  .tx_fifo_empty_o(tx_fifo_empty_o)
);

// File: tb/sim_uart_fifo_trig.sv
`timescale 1ns/1ps
module sim_uart_fifo_trig;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_cnt = '0, tx_cnt = '0;
  logic       busy = 1'b0;
  logic       rx_fine = 1'b0, tx_fine = 1'b0, tx_mode = 1'b0;
  logic [1:0] rx_sel = '0, tx_sel = '0;
  logic [3:0] rx_hi = '0, tx_hi = '0;
  logic       rx_irq, tx_irq, tx_empty;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  uart_fifo_trig u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_count_i(rx_cnt), .tx_count_i(tx_cnt), .tx_shift_busy_i(busy),
    .rx_fine_i(rx_fine), .rx_sel_i(rx_sel), .rx_hi_i(rx_hi),
    .tx_fine_i(tx_fine), .tx_sel_i(tx_sel), .tx_hi_i(tx_hi),
    .tx_empty_mode_i(tx_mode),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .tx_fifo_empty_o(tx_empty)
  );

  function automatic int rx_lvl(bit f, int s, int h);
    int v;
    if (!f) begin
      case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
    end
    v = h * 4 + s;
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int tx_lvl(bit f, int s, int h);
    int v;
    if (!f) begin
      case (s) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
    end
    v = h * 4 + s;
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // drive away from the edge, then sample just after the next edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check(rx_irq, 1'b0, "R1 rx_irq");
    check(tx_irq, 1'b1, "R1 tx_irq");
    check(tx_empty, 1'b1, "R1 tx_empty");
  endtask

  task automatic t_rx_coarse();
    for (int s = 0; s < 4; s++) begin
      int l;
      @(negedge clk); rx_fine = 0; rx_sel = 2'(s); rx_cnt = '0;
      step();
      l = rx_lvl(0, s, 0);
      @(negedge clk); rx_cnt = 7'(l - 1); step();
      check(rx_irq, 1'b0, "R2 below level");
      @(negedge clk); rx_cnt = 7'(l); step();
      check(rx_irq, 1'b1, "R2 at level");
    end
  endtask

  task automatic t_rx_fine();
    int hs[4] = '{0, 1, 8, 15};
    int ss[4] = '{1, 1, 1, 3};
    for (int i = 0; i < 4; i++) begin
      int l;
      l = rx_lvl(1, ss[i], hs[i]);
      @(negedge clk); rx_fine = 1; rx_sel = 2'(ss[i]); rx_hi = 4'(hs[i]); rx_cnt = 7'(l - 1);
      step();
      check(rx_irq, 1'b0, "R3 below fine level");
      @(negedge clk); rx_cnt = 7'(l); step();
      check(rx_irq, 1'b1, "R3 at fine level");
    end
  endtask

  task automatic t_fine_zero();
    @(negedge clk); rx_fine = 1; rx_sel = 0; rx_hi = 0; rx_cnt = 0; step();
    check(rx_irq, 1'b0, "R4 rx zero code, empty");
    @(negedge clk); rx_cnt = 1; step();
    check(rx_irq, 1'b1, "R4 rx zero code acts as 1");
    @(negedge clk); tx_mode = 0; tx_fine = 1; tx_sel = 0; tx_hi = 0; busy = 1; tx_cnt = 64; step();
    check(tx_irq, 1'b0, "R4 tx zero code, full");
    @(negedge clk); tx_cnt = 63; step();
    check(tx_irq, 1'b1, "R4 tx zero code acts as 1");
    busy = 0;
  endtask

  task automatic t_rx_drop();
    @(negedge clk); rx_fine = 0; rx_sel = 1; rx_cnt = 16; step();
    check(rx_irq, 1'b1, "R5 held at level");
    @(negedge clk); rx_cnt = 15; #1;
    check(rx_irq, 1'b0, "R5 drops with count, same cycle");
    @(negedge clk); rx_cnt = 40; #1;
    check(rx_irq, 1'b1, "R5 above level");
  endtask

  task automatic t_tx_normal();
    int l;
    @(negedge clk); tx_mode = 0; tx_fine = 0; tx_sel = 1; busy = 1;
    l = tx_lvl(0, 1, 0);
    tx_cnt = 7'(DEPTH - l); step();
    check(tx_irq, 1'b1, "R8 coarse 16 spaces free");
    @(negedge clk); tx_cnt = 7'(DEPTH - l + 1); step();
    check(tx_irq, 1'b0, "R7 one space short");
    @(negedge clk); tx_sel = 3; l = tx_lvl(0, 3, 0); tx_cnt = 7'(DEPTH - l); step();
    check(tx_irq, 1'b1, "R8 coarse 56 spaces free");
    @(negedge clk); tx_cnt = 7'(DEPTH - l + 1); step();
    check(tx_irq, 1'b0, "R8 coarse 56 one short");
    @(negedge clk); tx_fine = 1; tx_sel = 3; tx_hi = 15; l = tx_lvl(1, 3, 15);
    tx_cnt = 7'(DEPTH - l); step();
    check(tx_irq, 1'b1, "R8 fine 63 spaces");
    @(negedge clk); tx_cnt = 7'(DEPTH - l + 1); step();
    check(tx_irq, 1'b0, "R8 fine 63 one short");
    @(negedge clk); tx_cnt = 0; busy = 0; step();
    check(tx_irq, 1'b1, "R7 lane empty");
  endtask

  task automatic t_tx_empty_mode();
    @(negedge clk); tx_mode = 1; tx_fine = 0; tx_sel = 0; tx_cnt = 5; busy = 0; step();
    check(tx_irq, 1'b0, "R6 data left");
    @(negedge clk); tx_cnt = 0; busy = 1; step();
    check(tx_irq, 1'b0, "R6 shifter busy");
    @(negedge clk); busy = 0; step();
    check(tx_irq, 1'b1, "R6 lane idle");
    @(negedge clk); tx_mode = 0;
  endtask

  task automatic t_lsr();
    @(negedge clk); tx_cnt = 0; busy = 1; step();
    check(tx_empty, 1'b1, "R9 empty while shifting");
    @(negedge clk); tx_cnt = 1; step();
    check(tx_empty, 1'b0, "R9 one entry");
    @(negedge clk); busy = 0; tx_cnt = 0; step();
    check(tx_empty, 1'b1, "R9 empty idle");
  endtask

  task automatic t_cfg_latency();
    @(negedge clk); rx_fine = 0; rx_sel = 0; rx_cnt = 10; step();
    check(rx_irq, 1'b1, "R10 level 8 baseline");
    @(negedge clk); rx_sel = 3; #1;
    check(rx_irq, 1'b1, "R10 old cfg before edge");
    step();
    check(rx_irq, 1'b0, "R10 new cfg after edge");
    @(negedge clk); tx_mode = 1; tx_cnt = 10; busy = 0; #1;
    check(tx_irq, 1'b1, "R10 tx old mode before edge");
    step();
    check(tx_irq, 1'b0, "R10 tx new mode after edge");
    @(negedge clk); tx_mode = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    step();
    t_reset();
    t_rx_coarse();
    t_rx_fine();
    t_fine_zero();
    t_rx_drop();
    t_tx_normal();
    t_tx_empty_mode();
    t_lsr();
    t_cfg_latency();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule